// File: doc/BRIEF.md
# Byte Lane Strobe Generator

This block turns one static-memory access into the active-low control pins of the external bus. A separate access sequencer supplies the phase of the access: whether chip select is open and whether the read or write pulse is active. It also supplies the direction of the access and a per-lane byte-enable mask. The generator registers the chip select, the read strobe, a shared write strobe, four per-lane write strobes and four byte selects, so every pin changes on the same clock edge.

Two byte-access styles can be chosen at run time for 16- and 32-bit buses. In the per-lane style, each lane has its own write strobe, and reads use only the read strobe. In the shared style, a single write strobe and the read strobe are qualified by byte selects that are held for the whole chip-select window. A 2-bit width field sets which lanes may be driven. Its reserved code forces the bus quiet and raises an error flag.

The controller is a five-state machine. The states are ST_IDLE (no access), ST_SETUP (chip select open, no pulse yet), ST_PULSE (strobe active), ST_HOLD (after a pulse, chip select still open) and ST_FAULT (reserved width). The transitions are:
- IDLE→SETUP when chip select opens without a pulse.
- IDLE/SETUP/HOLD→PULSE when the pulse phase is present with chip select.
- PULSE→HOLD when the pulse ends.
- SETUP/PULSE/HOLD→IDLE when chip select closes.
- Any state→FAULT when the width code is reserved.
- FAULT stays while chip select stays open, and FAULT→IDLE otherwise.

Top module: `byte_lane_strobe`

## Requirements
- R1: Width code 2'b00 selects an 8-bit bus (lane 0 only), 2'b01 a 16-bit bus (lanes 0 and 1) and 2'b10 a 32-bit bus (lanes 0 to 3). A lane is driven only if its byte-enable bit is 1 and it lies inside the selected width.
- R2: On a 16-bit bus, write strobes and byte selects of lanes 2 and 3 stay high whatever the byte enables and style.
- R3: On an 8-bit bus the style input has no effect. Writes use the shared write strobe with byte select 0, and all per-lane write strobes stay high.
- R4: In per-lane style (cfg_lane_wr=1, 16/32-bit), a write pulse drives mem_wr_n[i] low for each active lane. mem_we_n, mem_rd_n and all byte selects stay high.
- R5: In per-lane style, a read pulse drives only mem_rd_n low (with chip select). All write strobes and byte selects stay high.
- R6: In shared style (cfg_lane_wr=0), a write pulse drives mem_we_n low. mem_bs_n[i] is low for each active lane during every cycle that chip select is asserted, and the per-lane write strobes stay high.
- R7: In shared style, a read pulse drives mem_rd_n low, with the same byte selects as R6. The write strobes stay high.
- R8: Every output is registered: it reflects the inputs sampled at the previous rising edge. During reset all strobes, byte selects and chip select are high and config_error is 0.
- R9: mem_cs_n is low exactly when acc_cs was sampled high (outside fault). A pulse phase without chip select drives no strobe, and no strobe is ever low while mem_cs_n is high.
- R10: Width code 2'b11 makes all pins high and config_error 1. The fault holds while acc_cs stays high, even if the width becomes legal, and clears once acc_cs is sampled low with a legal width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Bus width code |
| cfg_lane_wr | input | 1 | 1: per-lane write strobes, 0: shared strobe with byte selects |
| acc_cs | input | 1 | Chip-select phase from the sequencer |
| acc_pulse | input | 1 | Read/write pulse phase from the sequencer |
| acc_write | input | 1 | 1: write access, 0: read access |
| acc_be | input | 4 | Byte-enable mask, one bit per lane |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Shared write strobe, active low |
| mem_wr_n | output | 4 | Per-lane write strobes, active low |
| mem_bs_n | output | 4 | Per-lane byte selects, active low |
| config_error | output | 1 | Reserved width code seen |

## Verification
The assertions assume that the sequencer changes its phase, direction and configuration inputs only between clock edges. They also assume that acc_pulse is meaningful only inside an acc_cs window, although a stray pulse is tolerated and checked. The bench drives every input on the falling edge and uses legal phase orderings: setup, one or more pulse cycles, hold, then idle. It also applies a deliberate stray pulse and a reserved width code in the middle of an access, to reach the fault and the ignored-pulse paths.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        W8   = 2'b00,
        W16  = 2'b01,
        W32  = 2'b10,
        WRSV = 2'b11
    } width_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_FAULT
    } state_t;

endpackage

// File: rtl/bls_width_decode.sv
module bls_width_decode
    import bls_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic [1:0]       width_code,
    input  logic             lane_wr_cfg,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] lane_en,
    output logic             width_bad,
    output logic             per_lane_style
);

    localparam int unsigned HALF = LANES / 2;

    width_t w;
    assign w = width_t'(width_code);

    always_comb begin
        width_bad      = (w == WRSV);
        per_lane_style = lane_wr_cfg && ((w == W16) || (w == W32));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane_range
        localparam bit IS_FIRST = (i == 0);
        localparam bit IS_LOW   = (i < HALF);
        logic in_range;
        always_comb begin
            unique case (w)
                W8:      in_range = IS_FIRST;
                W16:     in_range = IS_LOW;
                W32:     in_range = 1'b1;
                default: in_range = 1'b0;
            endcase
            lane_en[i] = be[i] && in_range;
        end
    end

endmodule

// File: rtl/bls_seq.sv
module bls_seq
    import bls_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   acc_cs,
    input  logic   acc_pulse,
    input  logic   width_bad,
    output state_t state_nxt
);

    state_t state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        if (width_bad) begin
            state_nxt = ST_FAULT;
        end else begin
            unique case (state_q)
                ST_FAULT: state_nxt = acc_cs ? ST_FAULT : ST_IDLE;
                ST_IDLE: begin
                    if (!acc_cs)        state_nxt = ST_IDLE;
                    else if (acc_pulse) state_nxt = ST_PULSE;
                    else                state_nxt = ST_SETUP;
                end
                ST_SETUP: begin
                    if (!acc_cs)        state_nxt = ST_IDLE;
                    else if (acc_pulse) state_nxt = ST_PULSE;
                    else                state_nxt = ST_SETUP;
                end
                ST_PULSE, ST_HOLD: begin
                    if (!acc_cs)        state_nxt = ST_IDLE;
                    else if (acc_pulse) state_nxt = ST_PULSE;
                    else                state_nxt = ST_HOLD;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // R10: the fault state is left only through the idle state
    a_r10_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && !width_bad && !acc_cs) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/bls_lane_cell.sv
module bls_lane_cell (
    input  logic lane_en,
    input  logic in_window,
    input  logic in_pulse,
    input  logic is_write,
    input  logic per_lane_style,
    output logic wr_n_d,
    output logic bs_n_d
);

    always_comb begin
        wr_n_d = !(per_lane_style && is_write && in_pulse && lane_en);
        bs_n_d = !(!per_lane_style && in_window && lane_en);
    end

endmodule

// File: rtl/byte_lane_strobe.sv
module byte_lane_strobe
    import bls_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_lane_wr,
    input  logic             acc_cs,
    input  logic             acc_pulse,
    input  logic             acc_write,
    input  logic [LANES-1:0] acc_be,
    output logic             mem_cs_n,
    output logic             mem_rd_n,
    output logic             mem_we_n,
    output logic [LANES-1:0] mem_wr_n,
    output logic [LANES-1:0] mem_bs_n,
    output logic             config_error
);

    localparam int unsigned HALF = LANES / 2;

    logic [LANES-1:0] lane_en;
    logic             width_bad;
    logic             per_lane_style;
    state_t           state_nxt;
    logic             in_window;
    logic             in_pulse;
    logic [LANES-1:0] wr_n_d;
    logic [LANES-1:0] bs_n_d;

    bls_width_decode #(.LANES(LANES)) u_decode (
        .width_code     (cfg_width),
        .lane_wr_cfg    (cfg_lane_wr),
        .be             (acc_be),
        .lane_en        (lane_en),
        .width_bad      (width_bad),
        .per_lane_style (per_lane_style)
    );

    bls_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_cs    (acc_cs),
        .acc_pulse (acc_pulse),
        .width_bad (width_bad),
        .state_nxt (state_nxt)
    );

    always_comb begin
        in_window = (state_nxt == ST_SETUP) || (state_nxt == ST_PULSE) ||
                    (state_nxt == ST_HOLD);
        in_pulse  = (state_nxt == ST_PULSE);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bls_lane_cell u_cell (
            .lane_en        (lane_en[i]),
            .in_window      (in_window),
            .in_pulse       (in_pulse),
            .is_write       (acc_write),
            .per_lane_style (per_lane_style),
            .wr_n_d         (wr_n_d[i]),
            .bs_n_d         (bs_n_d[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n     <= 1'b1;
            mem_rd_n     <= 1'b1;
            mem_we_n     <= 1'b1;
            mem_wr_n     <= '1;
            mem_bs_n     <= '1;
            config_error <= 1'b0;
        end else begin
            mem_cs_n     <= !in_window;
            mem_rd_n     <= !(in_pulse && !acc_write);
            mem_we_n     <= !(in_pulse && acc_write && !per_lane_style);
            mem_wr_n     <= wr_n_d;
            mem_bs_n     <= bs_n_d;
            config_error <= (state_nxt == ST_FAULT);
        end
    end

    // R10: fault keeps every pin high
    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> (mem_cs_n && mem_rd_n && mem_we_n && (&mem_wr_n) && (&mem_bs_n)));

    // R10: fault persists while chip select is held
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (config_error && acc_cs) |=> config_error);

    // R2: upper lanes silent on a half-width bus
    a_r2_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_width == W16) |=> ((&mem_wr_n[LANES-1:HALF]) && (&mem_bs_n[LANES-1:HALF])));

    // R3: narrow bus never uses per-lane write strobes or upper byte selects
    a_r3_narrow_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_width == W8) |=> ((&mem_wr_n) && (&mem_bs_n[LANES-1:1])));

    // R9: no strobe or byte select without chip select
    a_r9_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_we_n || !(&mem_wr_n) || !(&mem_bs_n)) |-> !mem_cs_n);

    // R4: shared and per-lane write strobes never active together
    a_r4_write_styles_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !(&mem_wr_n)));

    // R5: a read strobe never overlaps a write strobe
    a_r5_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_we_n && (&mem_wr_n)));

endmodule

// File: tb/tb_byte_lane_strobe.sv
module tb_byte_lane_strobe;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_width = 2'b10;
    logic       cfg_lane_wr = 1'b0;
    logic       acc_cs = 1'b0;
    logic       acc_pulse = 1'b0;
    logic       acc_write = 1'b0;
    logic [3:0] acc_be = 4'h0;
    logic       mem_cs_n, mem_rd_n, mem_we_n, config_error;
    logic [3:0] mem_wr_n, mem_bs_n;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    bit model_fault = 0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_strobe dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_lane_wr(cfg_lane_wr),
        .acc_cs(acc_cs), .acc_pulse(acc_pulse), .acc_write(acc_write), .acc_be(acc_be),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
        .mem_wr_n(mem_wr_n), .mem_bs_n(mem_bs_n), .config_error(config_error)
    );

    function automatic logic [11:0] pins();
        return {mem_cs_n, mem_rd_n, mem_we_n, mem_wr_n, mem_bs_n, config_error};
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected pins
    task automatic step(input logic [1:0] w, input logic lw, input logic cs,
                        input logic pl, input logic wr, input logic [3:0] be,
                        input string tag);
        logic [3:0] range, m, wrn, bsn;
        logic style, pulse, fault;
        @(negedge clk);
        cfg_width = w; cfg_lane_wr = lw; acc_cs = cs;
        acc_pulse = pl; acc_write = wr; acc_be = be;
        fault = (w == 2'b11) || (model_fault && cs);
        model_fault = fault;
        if (fault) begin
            exp_q.push_back({3'b111, 4'hF, 4'hF, 1'b1});
        end else begin
            range = (w == 2'b00) ? 4'b0001 : (w == 2'b01) ? 4'b0011 : 4'b1111;
            m     = be & range;
            style = lw && (w != 2'b00);
            pulse = cs && pl;
            wrn   = ~((style && wr && pulse) ? m : 4'b0000);
            bsn   = ~((!style && cs) ? m : 4'b0000);
            exp_q.push_back({!cs, !(pulse && !wr), !(pulse && wr && !style), wrn, bsn, 1'b0});
        end
        tag_q.push_back(tag);
    endtask

    // Monitor: compares registered pins just after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [11:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pins() !== e) begin
                fails++;
                $display("FAIL %s: got %b expected %b", t, pins(), e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (pins() !== 12'b111_1111_1111_0) begin
            fails++;
            $display("FAIL R8 reset: got %b expected %b", pins(), 12'b111_1111_1111_0);
        end
        rst_n = 1'b1;

        // R6 R1: 32-bit shared style write, be 1011
        step(2'b10, 0, 1, 0, 1, 4'b1011, "R6 setup");
        step(2'b10, 0, 1, 1, 1, 4'b1011, "R6 pulse");
        step(2'b10, 0, 1, 1, 1, 4'b1011, "R6 pulse2");
        step(2'b10, 0, 1, 0, 1, 4'b1011, "R6 hold");
        step(2'b10, 0, 0, 0, 1, 4'b1011, "R8 idle");
        // R7: shared style read
        step(2'b10, 0, 1, 0, 0, 4'b0110, "R7 setup");
        step(2'b10, 0, 1, 1, 0, 4'b0110, "R7 pulse");
        step(2'b10, 0, 0, 0, 0, 4'b0110, "R7 idle");
        // R4: per-lane write
        step(2'b10, 1, 1, 0, 1, 4'b1101, "R4 setup");
        step(2'b10, 1, 1, 1, 1, 4'b1101, "R4 pulse");
        step(2'b10, 1, 1, 0, 1, 4'b1101, "R4 hold");
        // R5: per-lane read
        step(2'b10, 1, 1, 1, 0, 4'b1111, "R5 pulse");
        step(2'b10, 1, 0, 0, 0, 4'b1111, "R5 idle");
        // R2: 16-bit bus in both styles
        step(2'b01, 1, 1, 1, 1, 4'b1111, "R2 lane-wr write");
        step(2'b01, 0, 1, 1, 0, 4'b1111, "R2 shared read");
        step(2'b01, 0, 1, 1, 1, 4'b1110, "R2 shared write");
        step(2'b01, 0, 0, 0, 0, 4'b1111, "R2 idle");
        // R3: 8-bit bus ignores style
        step(2'b00, 1, 1, 1, 1, 4'b1111, "R3 write lane-wr cfg");
        step(2'b00, 0, 1, 1, 1, 4'b1111, "R3 write shared cfg");
        step(2'b00, 1, 1, 1, 0, 4'b0001, "R3 read");
        step(2'b00, 1, 0, 0, 0, 4'b0001, "R3 idle");
        // R9: pulse without chip select is ignored
        step(2'b10, 0, 0, 1, 1, 4'b1111, "R9 stray pulse");
        step(2'b10, 1, 0, 1, 0, 4'b1111, "R9 stray read");
        // R10: reserved width, sticky while cs held
        step(2'b10, 0, 1, 0, 1, 4'b1111, "R10 pre setup");
        step(2'b11, 0, 1, 1, 1, 4'b1111, "R10 reserved");
        step(2'b10, 0, 1, 1, 1, 4'b1111, "R10 sticky");
        step(2'b10, 0, 0, 0, 1, 4'b1111, "R10 clear");
        step(2'b10, 0, 1, 1, 1, 4'b0011, "R10 recovered");
        step(2'b11, 0, 0, 0, 0, 4'b0000, "R10 reserved idle");
        step(2'b10, 0, 0, 0, 0, 4'b0000, "R10 idle clear");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule